// File: doc/BRIEF.md
# Windowed Pixel Histogram Generator

The block watches a stream of 32-bit pixels and gathers per-frame statistics for the pixels inside a programmable rectangle. The rectangle can be thinned by separate horizontal and vertical subsampling ratios. Each accepted pixel feeds one or more histograms. Each histogram also tracks the largest and smallest value it has binned and a running sum of those values.

Three layouts are available. In the first, each of the three colour components gets its own 64-bin histogram. In the second, only the largest component of each pixel is binned into one 64-bin histogram. In the third, a single 256-bin histogram is kept and read through an index/data register pair. Software clears the statistics before a frame. It marks the frame's end with a pulse. It then reads the frozen results through a small register port.

Top module: `pixhist_top`

## Requirements
- R1: A pixel carries red in pix_data[23:16], green in [15:8] and blue in [7:0]; bits [31:24] are alpha and have no effect. Columns count from 0 at the pixel flagged pix_first and restart after each pixel flagged pix_eol, which also advances the line; cycles with pix_valid low are skipped.
- R2: A pixel is a candidate only when hofs <= x < hofs+hsize and vofs <= y < vofs+vsize. The offset register (address 0x001) holds hofs in [15:0] and vofs in [31:16]. The size register (0x002) holds hsize in [15:0] and vsize in [31:16]. A zero size counts nothing.
- R3: The mode register (0x003) holds a horizontal ratio in [11:8] and a vertical ratio in [15:12]. A candidate is accepted only when (x-hofs) is a multiple of hratio+1 and (y-vofs) is a multiple of vratio+1.
- R4: With mode bits [1:0] both zero, each accepted pixel increments bin c*64 + v[7:2] for every component c (0 red, 1 green, 2 blue) of value v. Bin k is read directly at address 0x100+k.
- R5: With mode bit 1 set and bit 0 clear, only the largest of the three components m is binned, into bin 64 + m[7:2] (the green slot). Red and blue bins and statistics stay cleared.
- R6: With mode bit 0 set, one 256-bin histogram is kept. It is indexed by the full 8-bit green value, or by the largest component when bit 1 is also set. Bin k is read by writing k to 0x004 and then reading 0x005.
- R7: For each component slot c, address 0x010+c returns the largest binned value in [15:8] and the smallest in [7:0]. Address 0x014+c returns the sum of the binned values. Only slot 1 is fed in the modes of R5 and R6. Read data appears one cycle after the read address.
- R8: After reset, and after a write with bit 0 set to address 0x000, every bin and sum is zero, every max is 0 and every min is 255 (stat word 0x000000FF), and accumulation is resumed.
- R9: A frame_end pulse freezes all bins and statistics until the next clear, so frames streamed in between change nothing.
- R10: Bin counters and sums saturate at their all-ones value instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_valid | input | 1 | Pixel present this cycle |
| pix_data | input | 32 | Alpha, red, green, blue bytes |
| pix_first | input | 1 | First pixel of a frame |
| pix_eol | input | 1 | Last pixel of a line |
| frame_end | input | 1 | End-of-frame pulse, freezes results |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW (10) | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | AW (10) | Register read address |
| rd_data | output | 32 | Registered read data |

## Verification
A 12x9 frame is streamed in which every component is a different linear function of the column and line. Idle bubbles are inserted, and alpha varies. This means a swapped component, a wrong byte lane or a miscounted coordinate moves counts to visibly different bins. The same frame runs under each layout with differing offsets, sizes and ratio pairs. An offset-only window separates crop errors from subsampling errors. Windows that overrun the frame, use a zero width, or use unequal horizontal and vertical ratios separate phase handling from bounds handling. A second unclered frame exposes missing freezing. A narrowed sum width, with full-frame windows, separates saturation from wrap-around.

// File: rtl/pixhist_pkg.sv
`timescale 1ns/1ps
package pixhist_pkg;
    localparam int NCH   = 3;
    localparam int VALW  = 8;
    localparam int NBIN  = 256;
    localparam int IDXW  = $clog2(NBIN);
    localparam int RATW  = 4;
    localparam int SUBW  = 6;

    localparam int A_CLEAR = 'h000;
    localparam int A_OFS   = 'h001;
    localparam int A_SIZE  = 'h002;
    localparam int A_MODE  = 'h003;
    localparam int A_IDX   = 'h004;
    localparam int A_IDATA = 'h005;
    localparam int A_MM    = 'h010;
    localparam int A_SUM   = 'h014;

    typedef logic [VALW-1:0] val_t;

    typedef struct packed {
        logic            wide;
        logic            maxsel;
        logic [RATW-1:0] hrat;
        logic [RATW-1:0] vrat;
    } mode_t;

    typedef struct packed {
        logic [NCH-1:0]            en;
        logic [NCH-1:0][VALW-1:0]  val;
        logic [NCH-1:0][IDXW-1:0]  idx;
    } route_t;

    function automatic val_t lane(logic [NCH*VALW-1:0] rgb, int c);
        return rgb[(NCH-1-c)*VALW +: VALW];
    endfunction

    function automatic val_t biggest(logic [NCH*VALW-1:0] rgb);
        val_t m = lane(rgb, 0);
        for (int c = 1; c < NCH; c++)
            if (lane(rgb, c) > m) m = lane(rgb, c);
        return m;
    endfunction

    function automatic route_t steer(mode_t m, logic [NCH*VALW-1:0] rgb);
        route_t r;
        val_t   top;
        r   = '0;
        top = biggest(rgb);
        if (m.wide) begin
            r.en[1]  = 1'b1;
            r.val[1] = m.maxsel ? top : lane(rgb, 1);
            r.idx[1] = IDXW'(r.val[1]);
        end else if (m.maxsel) begin
            r.en[1]  = 1'b1;
            r.val[1] = top;
            r.idx[1] = {2'd1, top[VALW-1 -: SUBW]};
        end else begin
            for (int c = 0; c < NCH; c++) begin
                r.en[c]  = 1'b1;
                r.val[c] = lane(rgb, c);
                r.idx[c] = {2'(c), r.val[c][VALW-1 -: SUBW]};
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/pixhist_window.sv
`timescale 1ns/1ps
module pixhist_window #(
    parameter int CW = 16,
    parameter int RW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pix_valid,
    input  logic          pix_first,
    input  logic          pix_eol,
    input  logic [CW-1:0] hofs,
    input  logic [CW-1:0] vofs,
    input  logic [CW-1:0] hsize,
    input  logic [CW-1:0] vsize,
    input  logic [RW-1:0] hrat,
    input  logic [RW-1:0] vrat,
    output logic          take
);
    logic [CW-1:0] xcnt, ycnt, cx, cy;
    logic [RW-1:0] hph, vph, eh, ev;
    logic          inx, iny;

    always_comb begin
        cx   = pix_first ? '0 : xcnt;
        cy   = pix_first ? '0 : ycnt;
        inx  = (cx >= hofs) && ((cx - hofs) < hsize);
        iny  = (cy >= vofs) && ((cy - vofs) < vsize);
        eh   = (cx == hofs) ? '0 : hph;
        ev   = (cy == vofs) ? '0 : vph;
        take = pix_valid && inx && iny && (eh == '0) && (ev == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            xcnt <= '0;
            ycnt <= '0;
            hph  <= '0;
            vph  <= '0;
        end else if (pix_valid) begin
            if (inx) hph <= (eh == hrat) ? '0 : RW'(eh + 1'b1);
            if (pix_eol) begin
                xcnt <= '0;
                ycnt <= CW'(cy + 1'b1);
                if (iny) vph <= (ev == vrat) ? '0 : RW'(ev + 1'b1);
            end else begin
                xcnt <= CW'(cx + 1'b1);
                ycnt <= cy;
            end
        end
    end
endmodule

// File: rtl/pixhist_chanstat.sv
`timescale 1ns/1ps
module pixhist_chanstat #(
    parameter int VW   = 8,
    parameter int SUMW = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr,
    input  logic            en,
    input  logic [VW-1:0]   val,
    output logic [VW-1:0]   vmax,
    output logic [VW-1:0]   vmin,
    output logic [SUMW-1:0] sum
);
    logic [SUMW:0] wide_sum;
    assign wide_sum = {1'b0, sum} + (SUMW+1)'(val);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            vmax <= '0;
            vmin <= '1;
            sum  <= '0;
        end else if (en) begin
            if (val > vmax) vmax <= val;
            if (val < vmin) vmin <= val;
            sum <= wide_sum[SUMW] ? '1 : wide_sum[SUMW-1:0];
        end
    end
endmodule

// File: rtl/pixhist_bins.sv
`timescale 1ns/1ps
module pixhist_bins #(
    parameter int NB   = 256,
    parameter int CNTW = 32,
    parameter int NP   = 3,
    localparam int IW  = $clog2(NB)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   clr,
    input  logic [NP-1:0]          inc,
    input  logic [NP-1:0][IW-1:0]  idx,
    input  logic [IW-1:0]          rd_idx,
    output logic [CNTW-1:0]        rd_cnt
);
    logic [CNTW-1:0] cnt [NB];
    logic [NB-1:0]   hit;

    always_comb begin
        hit = '0;
        for (int p = 0; p < NP; p++)
            if (inc[p]) hit[idx[p]] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            for (int i = 0; i < NB; i++) cnt[i] <= '0;
        end else begin
            for (int i = 0; i < NB; i++)
                if (hit[i] && (cnt[i] != '1)) cnt[i] <= cnt[i] + 1'b1;
        end
    end

    assign rd_cnt = cnt[rd_idx];
endmodule

// File: rtl/pixhist_top.sv
`timescale 1ns/1ps
module pixhist_top
    import pixhist_pkg::*;
#(
    parameter int AW   = 10,
    parameter int CW   = 16,
    parameter int CNTW = 32,
    parameter int SUMW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pix_valid,
    input  logic [31:0]   pix_data,
    input  logic          pix_first,
    input  logic          pix_eol,
    input  logic          frame_end,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [31:0]   wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [31:0]   rd_data
);
    localparam int DW = 32;

    logic [CW-1:0]   hofs, vofs, hsize, vsize;
    mode_t           mode;
    logic [IDXW-1:0] idx_reg;
    logic            frozen, clr, take, accept;
    route_t          rt;
    logic [NCH-1:0]  feed;
    logic [NCH-1:0][SUMW-1:0] sums;
    logic [NCH-1:0][VALW-1:0] maxs, mins;
    logic [IDXW-1:0] bin_sel;
    logic [CNTW-1:0] bin_rd;
    logic [DW-1:0]   rd_next;

    assign clr = wr_en && (wr_addr == AW'(A_CLEAR)) && wr_data[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            hofs <= '0; vofs <= '0; hsize <= '0; vsize <= '0;
            mode <= '0; idx_reg <= '0; frozen <= 1'b0;
        end else begin
            if (wr_en) begin
                if (wr_addr == AW'(A_OFS))  {vofs, hofs}   <= wr_data;
                if (wr_addr == AW'(A_SIZE)) {vsize, hsize} <= wr_data;
                if (wr_addr == AW'(A_MODE)) begin
                    mode.wide   <= wr_data[0];
                    mode.maxsel <= wr_data[1];
                    mode.hrat   <= wr_data[8 +: RATW];
                    mode.vrat   <= wr_data[12 +: RATW];
                end
                if (wr_addr == AW'(A_IDX)) idx_reg <= wr_data[IDXW-1:0];
            end
            if (clr)            frozen <= 1'b0;
            else if (frame_end) frozen <= 1'b1;
        end
    end

    pixhist_window #(.CW(CW), .RW(RATW)) u_win (
        .clk(clk), .rst(rst), .pix_valid(pix_valid), .pix_first(pix_first),
        .pix_eol(pix_eol), .hofs(hofs), .vofs(vofs), .hsize(hsize),
        .vsize(vsize), .hrat(mode.hrat), .vrat(mode.vrat), .take(take)
    );

    assign accept = take && !frozen;
    assign rt     = steer(mode, pix_data[NCH*VALW-1:0]);
    assign feed   = rt.en & {NCH{accept}};

    for (genvar g = 0; g < NCH; g++) begin : g_stat
        pixhist_chanstat #(.VW(VALW), .SUMW(SUMW)) u_stat (
            .clk(clk), .rst(rst), .clr(clr), .en(feed[g]), .val(rt.val[g]),
            .vmax(maxs[g]), .vmin(mins[g]), .sum(sums[g])
        );
    end

    assign bin_sel = (rd_addr == AW'(A_IDATA)) ? idx_reg : rd_addr[IDXW-1:0];

    pixhist_bins #(.NB(NBIN), .CNTW(CNTW), .NP(NCH)) u_bins (
        .clk(clk), .rst(rst), .clr(clr), .inc(feed), .idx(rt.idx),
        .rd_idx(bin_sel), .rd_cnt(bin_rd)
    );

    always_comb begin
        rd_next = '0;
        if (rd_addr[AW-1:IDXW] == (AW-IDXW)'(1)) rd_next = DW'(bin_rd);
        if (rd_addr == AW'(A_OFS))   rd_next = DW'({vofs, hofs});
        if (rd_addr == AW'(A_SIZE))  rd_next = DW'({vsize, hsize});
        if (rd_addr == AW'(A_MODE))  rd_next = DW'({mode.vrat, mode.hrat, 6'b0, mode.maxsel, mode.wide});
        if (rd_addr == AW'(A_IDX))   rd_next = DW'(idx_reg);
        if (rd_addr == AW'(A_IDATA)) rd_next = DW'(bin_rd);
        for (int c = 0; c < NCH; c++) begin
            if (rd_addr == AW'(A_MM + c))  rd_next = DW'({maxs[c], mins[c]});
            if (rd_addr == AW'(A_SUM + c)) rd_next = DW'(sums[c]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) rd_data <= '0;
        else     rd_data <= rd_next;
    end
endmodule

// File: rtl/pixhist_chk.sv
`timescale 1ns/1ps
module pixhist_chk
    import pixhist_pkg::*;
#(
    parameter int SUMW = 32
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     clr,
    input logic                     frozen,
    input logic                     take,
    input logic                     frame_end,
    input logic [NCH-1:0][SUMW-1:0] sums,
    input logic [NCH-1:0][VALW-1:0] maxs,
    input logic [NCH-1:0][VALW-1:0] mins
);
    // R8: a clear leaves every statistic in its cleared state
    assert_clear_state_R8: assert property (@(posedge clk) disable iff (rst)
        clr |=> (sums == '0) && (maxs == '0) && (mins == '1));

    // R9: frame end sets the freeze
    assert_freeze_set_R9: assert property (@(posedge clk) disable iff (rst)
        (frame_end && !clr) |=> frozen);

    // R9: while frozen nothing moves
    assert_freeze_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (frozen && !clr) |=> ($stable(sums) && $stable(maxs) && $stable(mins)));

    // R2: pixels outside the sampled window leave the statistics alone
    assert_outside_idle_R2: assert property (@(posedge clk) disable iff (rst)
        (!take && !clr) |=> ($stable(sums) && $stable(maxs) && $stable(mins)));

    for (genvar c = 0; c < NCH; c++) begin : g_sum
        // R10: sums never wrap downwards
        assert_no_wrap_R10: assert property (@(posedge clk) disable iff (rst)
            !clr |=> (sums[c] >= $past(sums[c])));
    end
endmodule

bind pixhist_top pixhist_chk #(.SUMW(SUMW)) u_chk (
    .clk(clk), .rst(rst), .clr(clr), .frozen(frozen), .take(take),
    .frame_end(frame_end), .sums(sums), .maxs(maxs), .mins(mins)
);

// File: tb/sim_pixhist_top.sv
`timescale 1ns/1ps
module sim_pixhist_top;
    localparam int SW = 12;
    localparam int FW = 12;
    localparam int FH = 9;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pix_valid = 1'b0, pix_first = 1'b0, pix_eol = 1'b0, frame_end = 1'b0;
    logic [31:0] pix_data = '0;
    logic        wr_en = 1'b0;
    logic [9:0]  wr_addr = '0, rd_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;

    always #2.5 clk = ~clk;

    pixhist_top #(.SUMW(SW)) u0 (
        .clk(clk), .rst(rst), .pix_valid(pix_valid), .pix_data(pix_data),
        .pix_first(pix_first), .pix_eol(pix_eol), .frame_end(frame_end),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    int checks = 0, errors = 0;
    int exp_bin [256];
    int exp_sum [3];
    int exp_max [3];
    int exp_min [3];

    function automatic int comp_at(int c, int x, int y);
        case (c)
            0:       return (x * 37 + y * 11) & 255;
            1:       return (x * 5 + y * 53 + 7) & 255;
            default: return (x * 91 + y * 3 + 200) & 255;
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wreg(int a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 10'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rreg(int a, output logic [31:0] v);
        @(negedge clk);
        rd_addr = 10'(a);
        @(negedge clk);
        v = rd_data;
    endtask

    task automatic add(int c, int idx, int v);
        exp_bin[idx]++;
        exp_sum[c] += v;
        if (v > exp_max[c]) exp_max[c] = v;
        if (v < exp_min[c]) exp_min[c] = v;
    endtask

    task automatic model(int ho, int vo, int hs, int vs, int hr, int vr, int wide, int mx);
        for (int i = 0; i < 256; i++) exp_bin[i] = 0;
        for (int c = 0; c < 3; c++) begin exp_sum[c] = 0; exp_max[c] = 0; exp_min[c] = 255; end
        for (int y = 0; y < FH; y++)
            for (int x = 0; x < FW; x++) begin
                int r, g, b, m;
                if (x < ho || x >= ho + hs || y < vo || y >= vo + vs) continue;
                if (((x - ho) % (hr + 1)) != 0 || ((y - vo) % (vr + 1)) != 0) continue;
                r = comp_at(0, x, y); g = comp_at(1, x, y); b = comp_at(2, x, y);
                m = r; if (g > m) m = g; if (b > m) m = b;
                if (wide != 0)    add(1, (mx != 0) ? m : g, (mx != 0) ? m : g);
                else if (mx != 0) add(1, 64 + m / 4, m);
                else begin
                    add(0, r / 4, r);
                    add(1, 64 + g / 4, g);
                    add(2, 128 + b / 4, b);
                end
            end
        for (int c = 0; c < 3; c++)
            if (exp_sum[c] > (1 << SW) - 1) exp_sum[c] = (1 << SW) - 1;
    endtask

    task automatic stream();
        for (int y = 0; y < FH; y++)
            for (int x = 0; x < FW; x++) begin
                @(negedge clk);
                if (((x + y) % 4) == 3) begin
                    pix_valid = 1'b0;
                    pix_data  = 32'hDEAD_BEEF;
                    @(negedge clk);
                end
                pix_valid = 1'b1;
                pix_first = (x == 0 && y == 0);
                pix_eol   = (x == FW - 1);
                pix_data  = {8'((x * 29) ^ (y * 7)), 8'(comp_at(0, x, y)),
                             8'(comp_at(1, x, y)), 8'(comp_at(2, x, y))};
            end
        @(negedge clk);
        pix_valid = 1'b0; pix_first = 1'b0; pix_eol = 1'b0;
        frame_end = 1'b1;
        @(negedge clk);
        frame_end = 1'b0;
    endtask

    task automatic verify(string tag, int wide);
        logic [31:0] v;
        for (int c = 0; c < 3; c++) begin
            rreg('h10 + c, v);
            chk({tag, " R7 maxmin"}, v, 32'((exp_max[c] << 8) | exp_min[c]));
            rreg('h14 + c, v);
            chk({tag, " R7 R10 sum"}, v, 32'(exp_sum[c]));
        end
        if (wide != 0) begin
            for (int i = 0; i < 256; i++) begin
                wreg('h004, 32'(i));
                rreg('h005, v);
                chk({tag, " R6 bin"}, v, 32'(exp_bin[i]));
            end
        end else begin
            for (int i = 0; i < 192; i++) begin
                rreg('h100 + i, v);
                chk({tag, " bin"}, v, 32'(exp_bin[i]));
            end
        end
    endtask

    task automatic run_cfg(string tag, int ho, int vo, int hs, int vs, int hr, int vr, int wide, int mx);
        wreg('h000, 32'd1);
        wreg('h001, 32'((vo << 16) | ho));
        wreg('h002, 32'((vs << 16) | hs));
        wreg('h003, 32'((vr << 12) | (hr << 8) | (mx << 1) | wide));
        model(ho, vo, hs, vs, hr, vr, wide, mx);
        stream();
        verify(tag, wide);
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R8: reset state
        for (int c = 0; c < 3; c++) begin
            rreg('h10 + c, v); chk("R8 reset maxmin", v, 32'h0000_00FF);
            rreg('h14 + c, v); chk("R8 reset sum", v, 32'h0);
        end
        rreg('h100, v); chk("R8 reset bin", v, 32'h0);

        // R1 R2 R4: offset-only crop, three histograms
        run_cfg("R1 R2 R4", 2, 1, 8, 6, 0, 0, 0, 0);
        // R9: second frame without clear changes nothing
        stream();
        verify("R9 frozen", 0);
        // R8: clear returns to the cleared state
        wreg('h000, 32'd1);
        for (int c = 0; c < 3; c++) begin
            rreg('h10 + c, v); chk("R8 clear maxmin", v, 32'h0000_00FF);
            rreg('h14 + c, v); chk("R8 clear sum", v, 32'h0);
        end
        rreg('h100 + 64 + 8, v); chk("R8 clear bin", v, 32'h0);

        run_cfg("R3 R4 ratios", 0, 0, 12, 9, 2, 1, 0, 0);
        run_cfg("R2 R3 R4 full", 0, 0, 12, 9, 0, 0, 0, 0);
        run_cfg("R5 R2 overrun", 3, 2, 20, 20, 1, 0, 0, 1);
        run_cfg("R6 R3 green", 1, 1, 10, 7, 0, 2, 1, 0);
        run_cfg("R6 R5 max", 0, 0, 12, 9, 1, 1, 1, 1);
        run_cfg("R2 zero width", 0, 0, 0, 9, 0, 0, 0, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule